// File: doc/BRIEF.md
# FIFO Occupancy Threshold Interrupt Unit

This block sits beside a pair of 8-entry FIFOs, one for receive and one for transmit, and turns their occupancy counts into threshold flags and an interrupt. Each direction has a 3-bit code that picks a fraction of the depth, counted in eighths. The receive flag compares the number of stored entries against the chosen fraction. The transmit flag compares the number of free entries against it. One code per direction selects an end case: completely full for receive, completely empty for transmit. Codes 6 and 7 are reserved and never raise a flag.

The flags are combinational from the occupancy counts, which the surrounding FIFOs already hold in registers. A flag whose enable bit is set feeds a registered interrupt line. Every pin is a plain control or status wire. No data passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `fifo_thresh_irq`

## Requirements
- R1: For receive code 0, 1, 2, 3 or 4, `rx_thresh` is high exactly when `rx_level` is at least 1, 2, 4, 6 or 7 respectively.
- R2: For receive code 5, `rx_thresh` is high only when `rx_level` equals 8, the FIFO depth.
- R3: For transmit code 0, 1, 2, 3 or 4, `tx_thresh` is high exactly when the free count (8 − `tx_level`) is at least 1, 2, 4, 6 or 7 respectively.
- R4: For transmit code 5, `tx_thresh` is high only when `tx_level` equals 0.
- R5: Codes 6 and 7 keep the flag of their direction low at every level.
- R6: `irq` at each rising edge takes the value (`rx_thresh` AND `rx_ie`) OR (`tx_thresh` AND `tx_ie`) from before that edge. A flag whose enable is low has no effect on `irq`.
- R7: While `rst_n` is low, `irq` is 0, whatever the flags and enables are.
- R8: The flags follow a change of level or code in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_level | input | 4 | Entries stored in the receive FIFO, 0 to 8 |
| tx_level | input | 4 | Entries stored in the transmit FIFO, 0 to 8 |
| rx_code | input | 3 | Receive threshold code |
| tx_code | input | 3 | Transmit threshold code |
| rx_ie | input | 1 | Receive threshold interrupt enable |
| tx_ie | input | 1 | Transmit threshold interrupt enable |
| rx_thresh | output | 1 | Receive threshold flag |
| tx_thresh | output | 1 | Transmit threshold flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest cases are the end points of the two code-5 rules. The receive flag has to stay low at 7 of 8 entries and rise only at 8. The transmit flag has to stay low with one entry stored and rise only at zero. Reserved codes must also stay quiet at those same extreme levels. The stimulus covers all of these by sweeping every pair of codes and every pair of levels at once, under all four enable combinations. The interrupt is checked one edge after each input change, so a wrong mix of the two directions shows up.

// File: rtl/fth_pkg.sv
package fth_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    FTH_EIGHTH   = 3'd0,
    FTH_QUARTER  = 3'd1,
    FTH_HALF     = 3'd2,
    FTH_3QUARTER = 3'd3,
    FTH_7EIGHTH  = 3'd4,
    FTH_WHOLE    = 3'd5,
    FTH_RSVD6    = 3'd6,
    FTH_RSVD7    = 3'd7
  } fth_code_e;

  // numerator in eighths for each usable code
  function automatic int fth_eighths(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 7;
      3'd5:    return 8;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/fth_target.sv
module fth_target
  import fth_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [CODE_W-1:0] code,
  output logic [LVL_W-1:0]  target,
  output logic              usable
);
  // ceiling of eighths*DEPTH/8, at least one entry
  function automatic logic [LVL_W-1:0] scale(input int num);
    int t;
    t = (num * DEPTH + 7) / 8;
    if (t < 1) t = 1;
    return LVL_W'(t);
  endfunction

  always_comb begin
    usable = 1'b1;
    target = '0;
    case (fth_code_e'(code))
      FTH_EIGHTH, FTH_QUARTER, FTH_HALF, FTH_3QUARTER, FTH_7EIGHTH:
        target = scale(fth_eighths(code));
      FTH_WHOLE: target = LVL_W'(DEPTH);
      default: usable = 1'b0;
    endcase
  end
endmodule

// File: rtl/fth_channel.sv
module fth_channel
  import fth_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter bit COUNT_FREE = 1'b0,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0]  level,
  input  logic [CODE_W-1:0] code,
  output logic              flag
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_sat, measured, target;
  logic             usable;

  assign lvl_sat = (level > FULL) ? FULL : level;

  generate
    if (COUNT_FREE) begin : g_free
      assign measured = FULL - lvl_sat;
    end else begin : g_used
      assign measured = lvl_sat;
    end
  endgenerate

  fth_target #(.DEPTH(DEPTH)) u_target (
    .code   (code),
    .target (target),
    .usable (usable)
  );

  assign flag = usable && (measured >= target);
endmodule

// File: rtl/fth_irq_reg.sv
module fth_irq_reg #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] enables,
  output logic             irq
);
  logic [N_SRC-1:0] masked;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_mask
      assign masked[i] = flags[i] & enables[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end

  // R6: with no enable set, irq drops at the next edge
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enables == '0) |=> !irq);
  // R6: any enabled flag shows on irq one edge later
  p_enabled_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & enables) != '0) |=> irq);
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
  import fth_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [CODE_W-1:0] rx_code,
  input  logic [CODE_W-1:0] tx_code,
  input  logic              rx_ie,
  input  logic              tx_ie,
  output logic              rx_thresh,
  output logic              tx_thresh,
  output logic              irq
);
  fth_channel #(.DEPTH(DEPTH), .COUNT_FREE(1'b0)) u_rx (
    .level (rx_level),
    .code  (rx_code),
    .flag  (rx_thresh)
  );

  fth_channel #(.DEPTH(DEPTH), .COUNT_FREE(1'b1)) u_tx (
    .level (tx_level),
    .code  (tx_code),
    .flag  (tx_thresh)
  );

  fth_irq_reg #(.N_SRC(2)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   ({tx_thresh, rx_thresh}),
    .enables ({tx_ie, rx_ie}),
    .irq     (irq)
  );

  p_rx_full_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_code == 3'd5 && rx_thresh) |-> (rx_level >= LVL_W'(DEPTH)));
  p_tx_empty_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_code == 3'd5 && tx_thresh) |-> (tx_level == '0));
  p_rsvd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_code >= 3'd6) |-> !rx_thresh) and ((tx_code >= 3'd6) |-> !tx_thresh));
  p_rx_empty_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_thresh);
  p_tx_full_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level >= LVL_W'(DEPTH)) |-> !tx_thresh);
endmodule

// File: tb/sim_fifo_thresh_irq.sv
module sim_fifo_thresh_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] rx_level = '0, tx_level = '0;
  logic [2:0] rx_code = '0, tx_code = '0;
  logic       rx_ie = 1'b0, tx_ie = 1'b0;
  logic       rx_thresh, tx_thresh, irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_thresh_irq u0 (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_code(rx_code), .tx_code(tx_code), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .irq(irq)
  );

  function automatic int need(input int code);
    case (code)
      0: return 1; 1: return 2; 2: return 4; 3: return 6; 4: return 7; 5: return 8;
      default: return 99;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rxc=%0d rxl=%0d txc=%0d txl=%0d ie=%b%b actual=%b expected=%b",
               req, rx_code, rx_level, tx_code, tx_level, rx_ie, tx_ie, act, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset holds irq low even with enabled flags
    rx_level = 4'd8; rx_ie = 1'b1; tx_ie = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R7", irq, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    for (int en = 0; en < 4; en++) begin
      for (int rc = 0; rc < 8; rc++) begin
        for (int tc = 0; tc < 8; tc++) begin
          for (int rl = 0; rl <= 8; rl++) begin
            for (int tl = 0; tl <= 8; tl++) begin
              logic erx, etx, eirq;
              @(negedge clk);
              rx_ie = en[0]; tx_ie = en[1];
              rx_code = 3'(rc); tx_code = 3'(tc);
              rx_level = 4'(rl); tx_level = 4'(tl);
              erx = (rl >= need(rc));
              etx = ((8 - tl) >= need(tc));
              eirq = (erx & en[0]) | (etx & en[1]);
              #1; // R8: flags settle with no clock edge
              if (rc < 5)       check("R1", rx_thresh, erx);
              else if (rc == 5) check("R2", rx_thresh, erx);
              else              check("R5", rx_thresh, erx);
              if (tc < 5)       check("R3", tx_thresh, etx);
              else if (tc == 5) check("R4", tx_thresh, etx);
              else              check("R5", tx_thresh, etx);
              @(posedge clk); #1;
              check("R6", irq, eirq);
            end
          end
        end
      end
    end

    // R7: reset in mid-run clears irq
    @(negedge clk);
    rx_code = 3'd0; rx_level = 4'd8; rx_ie = 1'b1;
    @(posedge clk); #1 check("R6", irq, 1'b1);
    rst_n = 1'b0; #1 check("R7", irq, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule